// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sits in the command path of an SDRAM controller. It takes a stream of read and write requests, each with a bank and a column, and turns them into a command bus of READ, WRITE and NOP. For a write that follows a read, it finds the earliest cycle on which the WRITE may go out without the memory and the controller driving the data bus at the same time. It also drives the data mask pin and the enable for the controller's own write-data drivers.

The mask pin acts on read output two clocks after it is sampled, and on write input in the same clock. When cutting a read burst short is faster than waiting for the burst to end, the scheduler raises the mask early enough to silence the unwanted read elements. It drops the mask exactly on the WRITE clock. A configuration flag adds one idle bus cycle between the last read element and the WRITE, for boards where the controller's drivers may switch on before the memory's outputs float. The CAS latency (2 or 3), the burst length and the flag are static inputs. They may change only while no command is in flight.

Top module: `sdram_turnaround`

## Requirements
- R1: The command output encodes NOP as 0, READ as 1 and WRITE as 2, and never shows 3. An accepted read request appears as READ, with its bank and column, in the cycle after the accepting clock edge.
- R2: An accepted write request with no read element still due at or after the next cycle (plus one cycle when `turn_gap` is 1) appears as WRITE in the cycle after the accepting edge.
- R3: Let R be the READ cycle, T the cycle after a write is accepted, L = R + CL + BL - 1 the last read element, F = L + 1 + gap and E = max(T + 2 + gap, R + CL + 1 + gap). If F > T and E >= F, the WRITE goes out in cycle F and the mask stays low throughout.
- R4: If F > T and E < F, the read burst is cut short. The WRITE goes out in cycle E, and the mask is high in every cycle from E - 2 - gap through E - 1 and low otherwise.
- R5: The mask is low in the WRITE cycle, in READ cycles and in every idle cycle.
- R6: When `turn_gap` is 1, no unmasked read element is on the bus in the cycle just before a WRITE.
- R7: The first element of a read burst is never masked. A WRITE that cuts a burst has the mask high in the two cycles before it.
- R8: With burst length one (`bl_sel` = 0), the mask is never asserted.
- R9: `wr_oe` rises only on the WRITE cycle and stays high for exactly BL cycles.
- R10: `req_ready` is low while a write waits for its slot or its data is still being driven. No READ is issued while `wr_oe` is high.
- R11: `cas_lat` carries CL (2 or 3). `bl_sel` selects the burst length BL = 1, 2, 4 or 8 for codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Request accepted at the clock edge when high together with req_valid |
| cas_lat | input | 2 | CAS latency, 2 or 3 |
| bl_sel | input | 2 | Burst length code: 0..3 gives 1, 2, 4, 8 |
| turn_gap | input | 1 | Add one idle bus cycle before a WRITE that follows read data |
| cmd | output | 2 | Command: 0 NOP, 1 READ, 2 WRITE |
| cmd_bank | output | BANK_W | Bank of the current command |
| cmd_col | output | COL_W | Column of the current command |
| dqm | output | 1 | Data mask pin |
| wr_oe | output | 1 | Output enable for the controller's write-data drivers |

## Verification
The assertions assume that `cas_lat`, `bl_sel` and `turn_gap` stay constant while a read burst or a pending write is in flight, and that `cas_lat` is only ever 2 or 3. The stimulus changes the configuration only after at least fourteen idle cycles, which outlasts any read burst, and draws CL from {2, 3} only. Requests are presented only when `req_ready` is high, so the scheduler never sees a request it would have to hold off in the middle of a turnaround.

// File: rtl/sdta_pkg.sv
package sdta_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } sd_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } sched_st_e;

    localparam int DELAY_W = 5;

    typedef struct packed {
        logic [DELAY_W-1:0] delay;
        logic               trunc;
    } wr_plan_t;

    function automatic int burst_len(input logic [1:0] code);
        return 1 << code;
    endfunction

    // s: cycles from the READ to the candidate write cycle T.
    // Result: cycles after T for the WRITE, and whether the burst is cut short.
    function automatic wr_plan_t plan_write(input int s, input int cl,
                                            input int bl, input int gap);
        wr_plan_t p;
        int full;
        int lo;
        full = cl + bl + gap - s;
        lo   = cl + 1 + gap - s;
        if (lo < 2 + gap) lo = 2 + gap;
        p.delay = '0;
        p.trunc = 1'b0;
        if (full > 0) begin
            if (lo < full) begin
                p.delay = DELAY_W'(lo);
                p.trunc = 1'b1;
            end else begin
                p.delay = DELAY_W'(full);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sdta_rd_tracker.sv
module sdta_rd_tracker #(
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_rd,
    input  logic [1:0]       cas_lat,
    input  logic [1:0]       bl_sel,
    output logic [AGE_W-1:0] age,
    output logic             rd_data_now
);
    import sdta_pkg::*;

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            age <= AGE_MAX;
        else if (issue_rd)
            age <= '0;
        else if (age != AGE_MAX)
            age <= age + 1'b1;
    end

    always_comb begin
        int a;
        int first;
        a = int'(age);
        first = int'(cas_lat);
        rd_data_now = (age != AGE_MAX) && (a >= first)
                      && (a <= first + burst_len(bl_sel) - 1);
    end

endmodule

// File: rtl/sdta_wr_burst.sv
module sdta_wr_burst #(
    parameter int LEFT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] bl_sel,
    output logic       wr_oe,
    output logic       busy
);
    import sdta_pkg::*;

    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_oe <= 1'b0;
            left  <= '0;
        end else if (start) begin
            wr_oe <= 1'b1;
            left  <= LEFT_W'(burst_len(bl_sel) - 1);
        end else if (left != '0) begin
            wr_oe <= 1'b1;
            left  <= left - 1'b1;
        end else begin
            wr_oe <= 1'b0;
        end
    end

    assign busy = (left != '0);

endmodule

// File: rtl/sdram_turnaround.sv
module sdram_turnaround #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int AGE_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    input  logic [1:0]        cas_lat,
    input  logic [1:0]        bl_sel,
    input  logic              turn_gap,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              dqm,
    output logic              wr_oe
);
    import sdta_pkg::*;

    localparam int LEFT_W = 3;

    sched_st_e          st;
    sd_cmd_e            cmd_q;
    logic [DELAY_W-1:0] cnt;
    logic               trunc_q;
    logic [BANK_W-1:0]  pend_bank;
    logic [COL_W-1:0]   pend_col;
    logic [AGE_W-1:0]   age;
    logic               rd_data_now;
    logic               wr_busy;
    logic               accept;
    logic               issue_rd;
    logic               issue_wr;
    logic               go_hold;
    wr_plan_t           plan;
    logic [DELAY_W:0]   mask_hi;

    sdta_rd_tracker #(.AGE_W(AGE_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .issue_rd   (issue_rd),
        .cas_lat    (cas_lat),
        .bl_sel     (bl_sel),
        .age        (age),
        .rd_data_now(rd_data_now)
    );

    sdta_wr_burst #(.LEFT_W(LEFT_W)) u_wr (
        .clk   (clk),
        .rst   (rst),
        .start (issue_wr),
        .bl_sel(bl_sel),
        .wr_oe (wr_oe),
        .busy  (wr_busy)
    );

    assign req_ready = (st == ST_IDLE) && !wr_busy;
    assign accept    = req_valid && req_ready;
    assign plan      = plan_write(int'(age) + 1, int'(cas_lat),
                                  burst_len(bl_sel), int'(turn_gap));
    assign mask_hi   = (DELAY_W+1)'(3) + (DELAY_W+1)'(turn_gap);
    assign issue_rd  = accept && !req_write;
    assign go_hold   = accept && req_write && (plan.delay != '0);
    assign issue_wr  = (accept && req_write && (plan.delay == '0))
                       || (st == ST_HOLD && cnt == DELAY_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cmd_q     <= CMD_NOP;
            cnt       <= '0;
            trunc_q   <= 1'b0;
            dqm       <= 1'b0;
            cmd_bank  <= '0;
            cmd_col   <= '0;
            pend_bank <= '0;
            pend_col  <= '0;
        end else begin
            cmd_q <= CMD_NOP;
            dqm   <= 1'b0;
            if (st == ST_IDLE) begin
                if (issue_rd || issue_wr) begin
                    cmd_q    <= issue_rd ? CMD_READ : CMD_WRITE;
                    cmd_bank <= req_bank;
                    cmd_col  <= req_col;
                end else if (go_hold) begin
                    st        <= ST_HOLD;
                    cnt       <= plan.delay;
                    trunc_q   <= plan.trunc;
                    pend_bank <= req_bank;
                    pend_col  <= req_col;
                    dqm       <= plan.trunc && ({1'b0, plan.delay} + 1'b1 <= mask_hi);
                end
            end else begin
                if (cnt == DELAY_W'(1)) begin
                    cmd_q    <= CMD_WRITE;
                    cmd_bank <= pend_bank;
                    cmd_col  <= pend_col;
                    st       <= ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                    dqm <= trunc_q && ({1'b0, cnt} <= mask_hi);
                end
            end
        end
    end

    assign cmd = cmd_q;

    // R1
    cmd_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmd != 2'd3);
    // R5
    write_dqm_low_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_WRITE |-> !dqm);
    // R7
    cut_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE && rd_data_now) |-> ($past(dqm) && $past(dqm, 2)));
    // R7
    first_elem_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_now && age == AGE_W'(cas_lat)) |-> !$past(dqm, 2));
    // R6
    gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE && turn_gap) |-> !($past(rd_data_now) && !$past(dqm, 3)));
    // R8
    bl1_nomask_chk: assert property (@(posedge clk) disable iff (rst)
        bl_sel == 2'd0 |-> !dqm);
    // R9
    oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_oe) |-> cmd == CMD_WRITE);
    // R10
    no_read_oe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_READ |-> !wr_oe);

endmodule

// File: tb/sdram_turnaround_tb.sv
module sdram_turnaround_tb;

    localparam int BANK_W = 2;
    localparam int COL_W  = 9;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_write;
    logic [BANK_W-1:0] req_bank;
    logic [COL_W-1:0]  req_col;
    logic              req_ready;
    logic [1:0]        cas_lat;
    logic [1:0]        bl_sel;
    logic              turn_gap;
    logic [1:0]        cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic              dqm;
    logic              wr_oe;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int last_rd = -1000;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_turnaround #(.BANK_W(BANK_W), .COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_ready(req_ready),
        .cas_lat(cas_lat), .bl_sel(bl_sel), .turn_gap(turn_gap),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .dqm(dqm), .wr_oe(wr_oe)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            summary();
        end
    end

    function automatic int bl_of(input logic [1:0] code);
        return 1 << code;
    endfunction

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cmd == 2'd0, "R5 idle cmd", cmd, 0);
            check(dqm == 1'b0, "R5 idle dqm", dqm, 0);
        end
    endtask

    task automatic do_read(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_bank = b; req_col = c;
        @(negedge clk);
        req_valid = 1'b0;
        last_rd = cyc;
        check(cmd == 2'd1, "R1 read cmd", cmd, 1);
        check(cmd_bank == b && cmd_col == c, "R1 read addr", int'(cmd_col), int'(c));
        check(dqm == 1'b0, "R5 dqm on read", dqm, 0);
        check(wr_oe == 1'b0, "R10 oe on read", wr_oe, 0);
    endtask

    task automatic do_write(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c);
        int t, cl, bl, gap, full, lo, w;
        bit cut;
        string tag;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_bank = b; req_col = c;
        t = cyc + 1;
        cl = int'(cas_lat); bl = bl_of(bl_sel); gap = int'(turn_gap);
        full = last_rd + cl + bl + gap;
        lo = t + 2 + gap;
        if (last_rd + cl + 1 + gap > lo) lo = last_rd + cl + 1 + gap;
        cut = 0;
        if (full <= t) begin w = t; tag = "R2"; end
        else if (lo < full) begin w = lo; cut = 1; tag = "R4"; end
        else begin w = full; tag = "R3"; end
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = t; k <= w + bl - 1; k++) begin
            if (k > t) @(negedge clk);
            check(cmd == ((k == w) ? 2'd2 : 2'd0), {tag, " write cmd"}, cmd, (k == w) ? 2 : 0);
            check(dqm == (cut && k >= w - 2 - gap && k <= w - 1), {tag, " R8 dqm"}, dqm,
                  int'(cut && k >= w - 2 - gap && k <= w - 1));
            check(wr_oe == (k >= w), "R9 oe window", wr_oe, int'(k >= w));
            if (k < w + bl - 1)
                check(req_ready == 1'b0, "R10 ready low", req_ready, 0);
            if (k == w)
                check(cmd_bank == b && cmd_col == c, "R1 write addr", int'(cmd_col), int'(c));
        end
        @(negedge clk);
        check(wr_oe == 1'b0, "R9 oe end", wr_oe, 0);
    endtask

    task automatic set_cfg(input int cl, input int bs, input int g);
        idle(14);
        cas_lat = 2'(cl); bl_sel = 2'(bs); turn_gap = g[0];
        idle(1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_col = '0;
        cas_lat = 2'd3; bl_sel = 2'd2; turn_gap = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd == 2'd0 && dqm == 1'b0 && wr_oe == 1'b0, "R5 reset outputs", cmd, 0);
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);

        // R4: CL3 BL4, write right after read cuts the burst
        do_read(2'd1, 9'd10);
        do_write(2'd2, 9'd20);
        // R2: write with nothing outstanding
        idle(10);
        do_write(2'd0, 9'd5);
        // R3: write late in the burst waits for its end
        do_read(2'd3, 9'd7);
        idle(4);
        do_write(2'd1, 9'd8);
        // R8: burst length one never masks
        set_cfg(3, 0, 0);
        do_read(2'd0, 9'd1);
        do_write(2'd0, 9'd2);
        // R6: extra gap with BL8
        set_cfg(2, 3, 1);
        do_read(2'd2, 9'd3);
        do_write(2'd2, 9'd4);
        // R11: CL2 BL2, back-to-back reads then write
        set_cfg(2, 1, 0);
        do_read(2'd0, 9'd9);
        do_read(2'd1, 9'd11);
        do_write(2'd3, 9'd12);
        do_read(2'd1, 9'd13);

        for (int i = 0; i < 600; i++) begin
            int op;
            if (i % 50 == 49) set_cfg(2 + int'($urandom % 2), int'($urandom % 4), int'($urandom % 2));
            op = int'($urandom % 4);
            if (op == 0 || op == 3) do_read(BANK_W'($urandom), COL_W'($urandom));
            else if (op == 1) do_write(BANK_W'($urandom), COL_W'($urandom));
            else idle(int'($urandom % 4));
        end
        idle(4);
        summary();
    end

endmodule